// File: doc/BRIEF.md
# LCD Timing Controller Interrupt Unit

This block is the register and interrupt part of an LCD timing controller. A host reaches it through a simple 32-bit register bus: one write strobe, one read strobe, a word index and data. Two words carry meaning. The control word holds the controller enable. The interrupt word holds the vertical-blank interrupt enable and the vertical-blank status flag. All other words in the lower half of the window are plain storage.

A free-running divider turns the system clock into a frame-rate event, by default sixty per second. When the interrupt enable is set, each event sets the status flag and raises a level interrupt. The interrupt stays high until software writes the interrupt word with the flag bit at zero. Accesses to the upper half of the window read as zero, store nothing and give a one-cycle error pulse.

A pixel path takes 32-bit framebuffer words and splits them into red, green and blue bytes, one cycle later. The path is gated by the controller enable.

Top module: `lcdt_irq_unit`

## Requirements
- R1: After reset every word reads zero, `vblank_irq` is low and `pix_out_valid` is low.
- R2: A write to any word index below half the window stores all 32 bits exactly. A read strobe returns that word on `bus_rdata` in the following cycle with `bus_err` low.
- R3: For a word index in the upper half of the window (most significant index bit set, byte offset 0x800 and up), a read returns zero and a read or write raises `bus_err` for exactly the following cycle. Such a write changes no stored word.
- R4: The frame event fires every CLK_HZ/FRAME_HZ clocks. The first event is at the FRAME_CLKS-th rising edge after reset release. If bit 31 of the interrupt word (index 1) is set at that edge, bit 14 of that word becomes 1 and `vblank_irq` goes high.
- R5: While bit 31 of the interrupt word is clear, frame events change neither bit 14 nor `vblank_irq`. This holds whatever the controller enable is.
- R6: Once high, `vblank_irq` stays high through later events and other accesses. A write to the interrupt word with bit 14 at zero drives it low in the next cycle and stores the written value.
- R7: A write to the interrupt word with bit 14 at one stores the written value and leaves `vblank_irq` unchanged.
- R8: With bit 31 of the control word (index 0) set, a valid input word gives `pix_out_valid` high one cycle later. Blue is taken from bits 7:0, green from 15:8 and red from 23:16. Bits 31:24 have no effect.
- R9: With bit 31 of the control word clear, `pix_out_valid` stays low and the colour outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_idx | input | IDX_W | Word index within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse for an upper-half access |
| pix_in_valid | input | 1 | Framebuffer word valid |
| pix_in_word | input | 32 | Framebuffer word, colour in bits 23:0 |
| pix_out_valid | output | 1 | Colour outputs valid |
| pix_red | output | 8 | Red channel |
| pix_grn | output | 8 | Green channel |
| pix_blu | output | 8 | Blue channel |
| vblank_irq | output | 1 | Level vertical-blank interrupt |

## Verification
The bench counts clock edges from reset release and checks the interrupt one cycle before and exactly at each expected frame event. A divider that is off by one would therefore show up as a misplaced edge. Clearing the interrupt is tried with the flag bit at one and at zero, so a design that clears on a written one, or never clears, gives the wrong level. A write-then-read sweep covers every storage word and every upper-half index. This exposes a decoder that aliases the upper half onto real storage or leaves the error pulse out. Pixel words with varied top bytes check the byte lanes and show whether the disabled path leaks valid outputs.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int WORD_W      = 32;
  localparam int CTRL_IDX    = 0;
  localparam int IRQ_IDX     = 1;
  localparam int ENABLE_BIT  = 31;
  localparam int VB_IE_BIT   = 31;
  localparam int VB_FLAG_BIT = 14;
  localparam int CHAN_W      = 8;

  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] grn;
    logic [CHAN_W-1:0] blu;
  } rgb_t;
endpackage

// File: rtl/lcdt_frame_tick.sv
module lcdt_frame_tick #(
  parameter int FRAME_CLKS = 1666666
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (FRAME_CLKS > 2) ? $clog2(FRAME_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcdt_reg_bank.sv
module lcdt_reg_bank
  import lcdt_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              vb_tick,
  output logic [WORD_W-1:0] rdata,
  output logic              err,
  output logic              ctrl_en,
  output logic              irq
);
  localparam int LOW_W = IDX_W - 1;
  localparam int HALF  = 1 << LOW_W;

  logic [WORD_W-1:0] words [HALF];
  logic              hit_hi;
  logic [LOW_W-1:0]  low_idx;
  logic              vb_ie;
  logic              vb_set;
  logic              irq_clr;

  assign hit_hi  = word_idx[IDX_W-1];
  assign low_idx = word_idx[LOW_W-1:0];
  assign vb_ie   = words[IRQ_IDX][VB_IE_BIT];
  assign vb_set  = vb_tick & vb_ie;
  assign ctrl_en = words[CTRL_IDX][ENABLE_BIT];
  assign irq_clr = wr_stb & ~hit_hi & (low_idx == LOW_W'(IRQ_IDX))
                 & ~wdata[VB_FLAG_BIT];

  for (genvar i = 0; i < HALF; i++) begin : g_word
    logic [WORD_W-1:0] q, d;
    logic              en, wr_hit;

    assign wr_hit = wr_stb & ~hit_hi & (low_idx == LOW_W'(i));

    if (i == IRQ_IDX) begin : g_irq_word
      always_comb begin
        d = wr_hit ? wdata : q;
        if (vb_set) d[VB_FLAG_BIT] = 1'b1;
      end
      assign en = wr_hit | vb_set;
    end else begin : g_plain_word
      assign d  = wdata;
      assign en = wr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[i] = q;
  end

  logic              irq_q, irq_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  always_comb begin
    if (vb_set)       irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
    rdata_d = hit_hi ? '0 : words[low_idx];
    err_d   = (rd_stb | wr_stb) & hit_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
      if (rd_stb) rdata_q <= rdata_d;
    end
  end

  assign irq   = irq_q;
  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/lcdt_pix_split.sv
module lcdt_pix_split
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output rgb_t              out_rgb
);
  rgb_t rgb_q, rgb_d;
  logic valid_q, valid_d;
  logic unused_pad;

  assign unused_pad = ^in_word[WORD_W-1:3*CHAN_W];

  always_comb begin
    valid_d   = in_valid & enable;
    rgb_d.blu = in_word[CHAN_W-1:0];
    rgb_d.grn = in_word[2*CHAN_W-1:CHAN_W];
    rgb_d.red = in_word[3*CHAN_W-1:2*CHAN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rgb_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) rgb_q <= rgb_d;
    end
  end

  assign out_valid = valid_q;
  assign out_rgb   = rgb_q;
endmodule

// File: rtl/lcdt_irq_unit.sv
module lcdt_irq_unit
  import lcdt_pkg::*;
#(
  parameter int CLK_HZ    = 100000000,
  parameter int FRAME_HZ  = 60,
  parameter int WIN_WORDS = 1024,
  localparam int IDX_W    = $clog2(WIN_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  input  logic             pix_in_valid,
  input  logic [31:0]      pix_in_word,
  output logic             pix_out_valid,
  output logic [7:0]       pix_red,
  output logic [7:0]       pix_grn,
  output logic [7:0]       pix_blu,
  output logic             vblank_irq
);
  localparam int FRAME_CLKS = CLK_HZ / FRAME_HZ;

  logic vb_tick;
  logic ctrl_en;
  rgb_t rgb;

  lcdt_frame_tick #(.FRAME_CLKS(FRAME_CLKS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (vb_tick)
  );

  lcdt_reg_bank #(.IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (bus_wr),
    .rd_stb  (bus_rd),
    .word_idx(bus_idx),
    .wdata   (bus_wdata),
    .vb_tick (vb_tick),
    .rdata   (bus_rdata),
    .err     (bus_err),
    .ctrl_en (ctrl_en),
    .irq     (vblank_irq)
  );

  lcdt_pix_split u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctrl_en),
    .in_valid (pix_in_valid),
    .in_word  (pix_in_word),
    .out_valid(pix_out_valid),
    .out_rgb  (rgb)
  );

  assign pix_red = rgb.red;
  assign pix_grn = rgb.grn;
  assign pix_blu = rgb.blu;
endmodule

// File: rtl/lcdt_irq_unit_chk.sv
module lcdt_irq_unit_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [IDX_W-1:0] bus_idx,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic             vb_tick,
  input logic             ctrl_en,
  input logic             pix_in_valid,
  input logic             pix_out_valid,
  input logic             vblank_irq
);
  logic clr_wr;
  logic hi_acc;
  assign clr_wr = bus_wr && (bus_idx == IDX_W'(1)) && !bus_wdata[14];
  assign hi_acc = (bus_rd || bus_wr) && bus_idx[IDX_W-1];

  assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank_irq) |-> $past(vb_tick));

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vb_tick |=> !vb_tick);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_irq && !clr_wr) |=> vblank_irq);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank_irq) |-> $past(clr_wr));

  assert_err_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(hi_acc));

  assert_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_idx[IDX_W-1]) |=> (bus_rdata == 32'h0 && bus_err));

  assert_pix_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_valid |-> $past(pix_in_valid && ctrl_en));
endmodule

bind lcdt_irq_unit lcdt_irq_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_idx      (bus_idx),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .vb_tick      (vb_tick),
  .ctrl_en      (ctrl_en),
  .pix_in_valid (pix_in_valid),
  .pix_out_valid(pix_out_valid),
  .vblank_irq   (vblank_irq)
);

// File: tb/lcdt_irq_unit_test.sv
module lcdt_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1200;
  localparam int FRAME_HZ   = 60;
  localparam int FRAME_N    = CLK_HZ / FRAME_HZ;
  localparam int WIN        = 64;
  localparam int IDX_W      = $clog2(WIN);
  localparam int HALF       = WIN / 2;

  logic             clk;
  logic             rst_n;
  logic             bus_wr, bus_rd;
  logic [IDX_W-1:0] bus_idx;
  logic [31:0]      bus_wdata, bus_rdata;
  logic             bus_err;
  logic             pix_in_valid;
  logic [31:0]      pix_in_word;
  logic             pix_out_valid;
  logic [7:0]       pix_red, pix_grn, pix_blu;
  logic             vblank_irq;

  int total = 0;
  int fails = 0;
  int ecnt  = 0;

  lcdt_irq_unit #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ), .WIN_WORDS(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pix_in_valid(pix_in_valid), .pix_in_word(pix_in_word),
    .pix_out_valid(pix_out_valid), .pix_red(pix_red), .pix_grn(pix_grn),
    .pix_blu(pix_blu), .vblank_irq(vblank_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_idx = IDX_W'(idx); bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] val, output logic err);
    @(negedge clk);
    bus_rd = 1'b1; bus_idx = IDX_W'(idx);
    @(negedge clk);
    bus_rd = 1'b0;
    val = bus_rdata; err = bus_err;
  endtask

  task automatic to_phase(input int ph);
    do @(negedge clk); while ((ecnt % FRAME_N) != ph);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E3779B9 * 32'(i)) ^ (32'(i) << 24) ^ 32'h0F1E2D3C;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        e;
    logic [23:0] last_rgb;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_idx = '0; bus_wdata = '0;
    pix_in_valid = 1'b0; pix_in_word = '0;
    repeat (3) @(negedge clk);
    check(!vblank_irq && !pix_out_valid && !bus_err, "R1 outputs in reset",
          {29'd0, vblank_irq, pix_out_valid, bus_err}, 32'h0);
    rst_n = 1'b1;

    // R1: storage cleared
    for (int i = 0; i < HALF; i++) begin
      bus_read(i, v, e);
      check(v == 32'h0, "R1 word after reset", v, 32'h0);
    end

    // R2: full sweep of plain storage
    for (int i = 2; i < HALF; i++) bus_write(i, pat(i));
    for (int i = 2; i < HALF; i++) begin
      bus_read(i, v, e);
      check(v == pat(i) && !e, "R2 readback", v, pat(i));
    end
    bus_write(0, 32'h0000_1234);
    bus_read(0, v, e);
    check(v == 32'h0000_1234, "R2 control word readback", v, 32'h0000_1234);

    // R3: upper half trapped
    for (int i = HALF; i < WIN; i++) begin
      bus_write(i, 32'hFFFF_FFFF);
      check(bus_err == 1'b1, "R3 write error pulse", {31'd0, bus_err}, 32'h1);
      bus_read(i, v, e);
      check(v == 32'h0 && e, "R3 upper read zero", v, 32'h0);
      @(negedge clk);
      check(bus_err == 1'b0, "R3 error lasts one cycle", {31'd0, bus_err}, 32'h0);
    end
    for (int i = 2; i < HALF; i++) begin
      bus_read(i, v, e);
      check(v == pat(i), "R3 no alias into storage", v, pat(i));
    end

    // R5: events with interrupt enable clear
    to_phase(0);
    check(!vblank_irq, "R5 event ignored while disabled", {31'd0, vblank_irq}, 32'h0);
    bus_read(1, v, e);
    check(v == 32'h0, "R5 flag stays clear", v, 32'h0);

    // R4: enable and check exact event edge
    bus_write(1, 32'h8000_0000);
    to_phase(FRAME_N - 1);
    check(!vblank_irq, "R4 low before event", {31'd0, vblank_irq}, 32'h0);
    @(negedge clk);
    check(vblank_irq, "R4 high at event", {31'd0, vblank_irq}, 32'h1);
    bus_read(1, v, e);
    check(v == 32'h8000_4000, "R4 flag set", v, 32'h8000_4000);

    // R6: level holds over later events
    to_phase(1);
    check(vblank_irq, "R6 holds after next event", {31'd0, vblank_irq}, 32'h1);
    to_phase(2);
    // R7: write with flag at one keeps level
    bus_write(1, 32'h8000_4000);
    check(vblank_irq, "R7 flag-one write keeps irq", {31'd0, vblank_irq}, 32'h1);
    bus_write(1, 32'h8000_0000);
    check(!vblank_irq, "R6 flag-zero write clears irq", {31'd0, vblank_irq}, 32'h0);
    bus_read(1, v, e);
    check(v == 32'h8000_0000, "R6 written value stored", v, 32'h8000_0000);
    to_phase(0);
    check(vblank_irq, "R4 re-raised on next event", {31'd0, vblank_irq}, 32'h1);
    to_phase(2);
    bus_write(1, 32'h0000_0000);
    check(!vblank_irq, "R6 clear and disable", {31'd0, vblank_irq}, 32'h0);
    bus_write(0, 32'h8000_0000);
    to_phase(0);
    check(!vblank_irq, "R5 ignored with controller enabled", {31'd0, vblank_irq}, 32'h0);

    // R8: pixel split sweep
    last_rgb = '0;
    for (int k = 0; k < 48; k++) begin
      logic [7:0] r, g, b;
      r = 8'(k * 11 + 5); g = 8'(k * 29 + 3); b = 8'(255 - k * 5);
      @(negedge clk);
      pix_in_valid = 1'b1;
      pix_in_word = {8'(k * 37), r, g, b};
      @(negedge clk);
      pix_in_valid = 1'b0;
      last_rgb = {r, g, b};
      check(pix_out_valid && {pix_red, pix_grn, pix_blu} == last_rgb,
            "R8 channel split", {7'd0, pix_out_valid, pix_red, pix_grn, pix_blu},
            {8'h01, last_rgb});
      @(negedge clk);
      check(!pix_out_valid, "R8 valid one cycle", {31'd0, pix_out_valid}, 32'h0);
    end
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_word = {8'hFF, last_rgb};
    @(negedge clk);
    pix_in_valid = 1'b0;
    check({pix_red, pix_grn, pix_blu} == last_rgb, "R8 top byte ignored",
          {8'd0, pix_red, pix_grn, pix_blu}, {8'd0, last_rgb});

    // R9: disabled path
    bus_write(0, 32'h7FFF_FFFF);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_word = 32'h0011_2233;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check(!pix_out_valid, "R9 no output while disabled", {31'd0, pix_out_valid}, 32'h0);
    check({pix_red, pix_grn, pix_blu} == last_rgb, "R9 channels hold",
          {8'd0, pix_red, pix_grn, pix_blu}, {8'd0, last_rgb});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule